// File: doc/BRIEF.md
# Descriptor-Fetching Memory Copy Channel

This block is one memory-to-memory copy channel. Software places a four-word descriptor in memory and writes its byte address into the channel's descriptor-pointer register. It then writes 1 to the run bit of the control/status register. The channel reads the descriptor over its memory master port. The four words are a flags word, a source address, a destination address and a byte count. The channel then copies the data as a sequence of 32-bit read/write pairs.

When the last word has been written, the run bit returns to 0 by itself. If the descriptor asked for it, a sticky completion flag is raised. The flag drives the `irq` output, and software clears it by writing 1 to it. Each address either steps by four bytes per word or stays fixed, according to its own flag. A fixed address allows copying from or into a single location.

Top module: `cbdma_channel`

## Requirements
- R1: After reset the control/status register (offset 0x00) and the descriptor-pointer register (offset 0x04) read 0, `irq` is 0 and no memory request is issued.
- R2: Writing a value with bit 0 set to offset 0x00 while idle starts the channel. It reads four descriptor words from the pointer address plus 0, 4, 8 and 12: flags, source, destination and byte count, in that order. A value written to offset 0x04 reads back unchanged.
- R3: A byte count of N (a multiple of 4) produces N/4 copy beats. Each beat reads one word at the current source address and then writes that word to the current destination address.
- R4: Flags bit 8 set makes the source address advance by 4 after each beat, and flags bit 4 does the same for the destination. With the bit clear, that address stays the same for every beat.
- R5: Control/status bit 0 reads 1 while a job runs. It reads 0 from the clock cycle that follows the acceptance of the final write.
- R6: If flags bit 0 is set, control/status bit 2 and `irq` become 1 when the job completes. If flags bit 0 is clear, they stay 0.
- R7: Writing a value with bit 2 set to offset 0x00 clears bit 2 and `irq`. A write with bit 2 clear leaves them unchanged.
- R8: A write setting bit 0 while a job runs is ignored: no second job starts and no extra memory traffic occurs.
- R9: A memory request holds its valid, address, direction and write data until it is accepted. Only one request is outstanding, and read data is taken on `mem_rsp_valid`.
- R10: A byte count of 0 completes right after the descriptor is read, with no data reads or writes. The completion flag follows the R6 rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | RAW (8) | Register byte offset |
| reg_wdata | input | DW (32) | Register write data |
| reg_rdata | output | DW (32) | Register read data for `reg_addr` (combinational) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW (32) | Byte address of the request |
| mem_req_wdata | output | DW (32) | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | DW (32) | Read data |
| irq | output | 1 | Completion flag (control/status bit 2) |

## Verification
The bench targets the combinations of the two increment flags. A design with the flags swapped or ignored leaves the wrong words at the destination. Stalled acceptance is exercised to expose a design that drops or alters a request before it is accepted. A zero byte count is checked to catch a design that still performs one beat or wraps the beat counter. The bench times the run-bit drop to the cycle after the last write, tries to restart the channel mid-job, and writes a clear value without bit 2 set; each of these catches a design that lets the completion flag or the run bit respond to the wrong event.

// File: rtl/cbdma_pkg.sv
// Shared constants and types for the descriptor-fetching copy channel.
// Assumes a 32-bit register file and a byte-addressed memory space.
package cbdma_pkg;

    // register offsets
    localparam int unsigned OFF_CTRL   = 0;
    localparam int unsigned OFF_DESC   = 4;

    // control/status bit positions
    localparam int unsigned CTRL_RUN   = 0;
    localparam int unsigned CTRL_DONE  = 2;

    // descriptor flags bit positions
    localparam int unsigned FLG_IRQ_EN = 0;
    localparam int unsigned FLG_DSTINC = 4;
    localparam int unsigned FLG_SRCINC = 8;

    // descriptor size in words
    localparam int unsigned DESC_WORDS = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_FWAIT,
        ST_READ,
        ST_RWAIT,
        ST_WRITE
    } eng_state_t;

endpackage

// File: rtl/cbdma_regs.sv
// Register slave of the copy channel: the control/status word and the
// descriptor pointer. Produces a one-cycle start pulse, accepted only while
// the engine is idle, and holds the sticky completion flag, which is cleared
// by writing one to it. Assumes reads are side-effect free.
module cbdma_regs
    import cbdma_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int RAW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [RAW-1:0] addr,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata,
    input  logic           busy,
    input  logic           done_irq,
    output logic           start,
    output logic [AW-1:0]  desc_ptr,
    output logic           flag
);

    logic ctrl_hit;
    logic desc_hit;

    assign ctrl_hit = wr_en && (addr == RAW'(OFF_CTRL));
    assign desc_hit = wr_en && (addr == RAW'(OFF_DESC));

    // start request: run bit written while the engine is idle
    assign start = ctrl_hit && wdata[CTRL_RUN] && !busy;

    // descriptor pointer storage and sticky completion flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_ptr <= '0;
            flag     <= 1'b0;
        end else begin
            if (desc_hit) begin
                desc_ptr <= wdata[AW-1:0];
            end
            if (done_irq) begin
                flag <= 1'b1;
            end else if (ctrl_hit && wdata[CTRL_DONE]) begin
                flag <= 1'b0;
            end
        end
    end

    // read mux over the two registers
    always_comb begin
        rdata = '0;
        if (addr == RAW'(OFF_CTRL)) begin
            rdata[CTRL_RUN]  = busy;
            rdata[CTRL_DONE] = flag;
        end else if (addr == RAW'(OFF_DESC)) begin
            rdata[AW-1:0] = desc_ptr;
        end
    end

endmodule

// File: rtl/cbdma_engine.sv
// Sequencer of the copy channel. It reads the four-word descriptor and then
// runs read/write beat pairs. It keeps one memory request outstanding and
// holds each request stable until it is accepted. Assumes the byte count is a
// multiple of four; its low two bits are dropped.
module cbdma_engine
    import cbdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] desc_ptr,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic          mem_req_write,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_wdata,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_rdata,
    output logic          busy,
    output logic          done,
    output logic          done_irq
);

    localparam int CW = DW - 2;
    localparam int IW = $clog2(DESC_WORDS);

    eng_state_t    state;
    logic [IW-1:0] idx;
    logic [AW-1:0] desc_q;
    logic [DW-1:0] flags_q;
    logic [AW-1:0] src_q;
    logic [AW-1:0] dst_q;
    logic [CW-1:0] beats_q;
    logic [DW-1:0] data_q;
    logic          last_fetch;
    logic          empty_job;
    logic          last_write;

    assign last_fetch = (state == ST_FWAIT) && mem_rsp_valid && (idx == IW'(DESC_WORDS - 1));
    assign empty_job  = last_fetch && (mem_rsp_rdata[DW-1:2] == '0);
    assign last_write = (state == ST_WRITE) && mem_req_ready && (beats_q == CW'(1));

    // completion strobes seen by the register slave on the finishing edge
    assign done     = empty_job || last_write;
    assign done_irq = done && flags_q[FLG_IRQ_EN];
    assign busy     = (state != ST_IDLE);

    // state sequencing and descriptor/pointer storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            idx     <= '0;
            desc_q  <= '0;
            flags_q <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            beats_q <= '0;
            data_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        desc_q <= desc_ptr;
                        idx    <= '0;
                        state  <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (mem_req_ready) state <= ST_FWAIT;
                end
                ST_FWAIT: begin
                    if (mem_rsp_valid) begin
                        case (idx)
                            IW'(0):  flags_q <= mem_rsp_rdata;
                            IW'(1):  src_q   <= mem_rsp_rdata[AW-1:0];
                            IW'(2):  dst_q   <= mem_rsp_rdata[AW-1:0];
                            default: beats_q <= mem_rsp_rdata[DW-1:2];
                        endcase
                        if (last_fetch) begin
                            state <= empty_job ? ST_IDLE : ST_READ;
                        end else begin
                            idx   <= idx + IW'(1);
                            state <= ST_FETCH;
                        end
                    end
                end
                ST_READ: begin
                    if (mem_req_ready) state <= ST_RWAIT;
                end
                ST_RWAIT: begin
                    if (mem_rsp_valid) begin
                        data_q <= mem_rsp_rdata;
                        state  <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (mem_req_ready) begin
                        beats_q <= beats_q - CW'(1);
                        if (flags_q[FLG_SRCINC]) src_q <= src_q + AW'(4);
                        if (flags_q[FLG_DSTINC]) dst_q <= dst_q + AW'(4);
                        state <= last_write ? ST_IDLE : ST_READ;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // request outputs decoded from the state
    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = '0;
        mem_req_wdata = data_q;
        case (state)
            ST_FETCH: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = desc_q + AW'({idx, 2'b00});
            end
            ST_READ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = src_q;
            end
            ST_WRITE: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = dst_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cbdma_channel.sv
// Top of the descriptor-fetching copy channel. It joins the register slave
// and the sequencer. Assumes a single clock domain and a memory that answers
// each accepted read with exactly one mem_rsp_valid pulse.
module cbdma_channel #(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int RAW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_wr_en,
    input  logic [RAW-1:0] reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    output logic           mem_req_valid,
    input  logic           mem_req_ready,
    output logic           mem_req_write,
    output logic [AW-1:0]  mem_req_addr,
    output logic [DW-1:0]  mem_req_wdata,
    input  logic           mem_rsp_valid,
    input  logic [DW-1:0]  mem_rsp_rdata,
    output logic           irq
);

    logic          busy;
    logic          done;
    logic          done_irq;
    logic          start;
    logic [AW-1:0] desc_ptr;

    cbdma_regs #(.AW(AW), .DW(DW), .RAW(RAW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .busy     (busy),
        .done_irq (done_irq),
        .start    (start),
        .desc_ptr (desc_ptr),
        .flag     (irq)
    );

    cbdma_engine #(.AW(AW), .DW(DW)) u_eng (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .desc_ptr      (desc_ptr),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_rdata (mem_rsp_rdata),
        .busy          (busy),
        .done          (done),
        .done_irq      (done_irq)
    );

endmodule

// File: rtl/cbdma_channel_chk.sv
// Protocol and sequencing checks for the copy channel, bound to its top.
module cbdma_channel_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req_valid,
    input logic          mem_req_ready,
    input logic          mem_req_write,
    input logic [AW-1:0] mem_req_addr,
    input logic [DW-1:0] mem_req_wdata,
    input logic          busy,
    input logic          done,
    input logic          done_irq,
    input logic          irq
);

    // R9: an unaccepted request keeps all its fields
    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_write) && $stable(mem_req_wdata));

    // R1: no memory traffic unless a job is running
    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> busy);

    // R5: run bit drops right after completion
    a_r5_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R5: run bit never drops without completion
    a_r5_fall_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

    // R6: an enabled completion raises the flag
    a_r6_flag_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> irq);

    // R6: the flag only rises from an enabled completion
    a_r6_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(done_irq));

endmodule

bind cbdma_channel cbdma_channel_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .busy          (busy),
    .done          (done),
    .done_irq      (done_irq),
    .irq           (irq)
);

// File: tb/cbdma_channel_tb.sv
`timescale 1ns/1ps
module cbdma_channel_tb;

    localparam int AW  = 32;
    localparam int DW  = 32;
    localparam int RAW = 8;
    localparam logic [31:0] DESC_A = 32'h300;
    localparam logic [31:0] DESC_B = 32'h380;

    typedef struct packed {
        logic [31:0] flags;
        logic [31:0] src;
        logic [31:0] dst;
        logic [31:0] len;
        logic        stall;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{32'h111, 32'h000, 32'h080, 32'd32, 1'b0},
        '{32'h111, 32'h000, 32'h100, 32'd32, 1'b1},
        '{32'h110, 32'h040, 32'h0C0, 32'd16, 1'b0},
        '{32'h011, 32'h020, 32'h140, 32'd12, 1'b0},
        '{32'h101, 32'h040, 32'h1C0, 32'd20, 1'b1},
        '{32'h001, 32'h000, 32'h200, 32'd0,  1'b0},
        '{32'h111, 32'h060, 32'h240, 32'd4,  1'b1}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           reg_wr_en = 1'b0;
    logic [RAW-1:0] reg_addr = '0;
    logic [DW-1:0]  reg_wdata = '0;
    logic [DW-1:0]  reg_rdata;
    logic           mem_req_valid;
    logic           mem_req_ready;
    logic           mem_req_write;
    logic [AW-1:0]  mem_req_addr;
    logic [DW-1:0]  mem_req_wdata;
    logic           mem_rsp_valid = 1'b0;
    logic [DW-1:0]  mem_rsp_rdata = '0;
    logic           irq;

    logic [31:0] mem    [256];
    logic [31:0] shadow [256];
    logic        stall_mode = 1'b0;
    int          cyc = 0;
    int          n_wr = 0;
    int          n_rd = 0;
    int          last_wr_cyc = 0;
    int          checks = 0;
    int          errors = 0;
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;

    assign mem_req_ready = !stall_mode || cyc[0];

    cbdma_channel #(.AW(AW), .DW(DW), .RAW(RAW)) u_dut (
        .clk, .rst_n, .reg_wr_en, .reg_addr, .reg_wdata, .reg_rdata,
        .mem_req_valid, .mem_req_ready, .mem_req_write, .mem_req_addr,
        .mem_req_wdata, .mem_rsp_valid, .mem_rsp_rdata, .irq
    );

    // memory model: one-cycle read latency, writes on acceptance
    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
                mem[mem_req_addr[9:2]] <= mem_req_wdata;
                n_wr <= n_wr + 1;
                last_wr_cyc <= cyc;
            end else begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_rdata <= mem[mem_req_addr[9:2]];
                n_rd <= n_rd + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [RAW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [RAW-1:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.1;
        d = reg_rdata;
    endtask

    task automatic put(input logic [31:0] a, input logic [31:0] d);
        mem[a[9:2]] = d;
        shadow[a[9:2]] = d;
    endtask

    task automatic fill(input int tag);
        for (int i = 0; i < 256; i++) put(32'(i * 4), {8'(tag), 24'(i * 7919)});
    endtask

    task automatic set_desc(input logic [31:0] at, input vec_t v);
        put(at, v.flags); put(at + 4, v.src); put(at + 8, v.dst); put(at + 12, v.len);
    endtask

    // reference copy on the shadow image, from the requirement text
    task automatic model(input vec_t v);
        logic [31:0] s, d;
        s = v.src; d = v.dst;
        for (int i = 0; i < int'(v.len >> 2); i++) begin
            shadow[d[9:2]] = shadow[s[9:2]];
            if (v.flags[8]) s = s + 4;
            if (v.flags[4]) d = d + 4;
        end
    endtask

    task automatic mem_compare(input string req);
        int bad;
        bad = -1;
        for (int i = 0; i < 256; i++) if (bad < 0 && mem[i] !== shadow[i]) bad = i;
        if (bad < 0) check(1'b1, req, 0, 0);
        else check(1'b0, req, mem[bad], shadow[bad]);
    endtask

    // poll run bit until clear; returns cycle counter at first idle sample
    task automatic wait_idle(output int idle_cyc);
        logic [31:0] r;
        idle_cyc = -1;
        for (int t = 0; t < 3000 && idle_cyc < 0; t++) begin
            reg_rd(8'h00, r);
            if (r[0] == 1'b0) idle_cyc = cyc;
            else @(negedge clk);
        end
        if (idle_cyc < 0) check(1'b0, "R5 completion timeout", 1, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int idle, wr0, rd0;
        fill(0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        reg_rd(8'h00, r); check(r == 0, "R1 ctrl reset", r, 0);
        reg_rd(8'h04, r); check(r == 0, "R1 desc ptr reset", r, 0);
        check(irq == 0 && mem_req_valid == 0, "R1 outputs idle", {irq, mem_req_valid}, 0);

        // vector table: R2 R3 R4 R5 R6 R10
        for (int v = 0; v < NV; v++) begin
            fill(v + 1);
            set_desc(DESC_A, VECS[v]);
            model(VECS[v]);
            stall_mode = VECS[v].stall;
            reg_wr(8'h04, DESC_A);
            reg_rd(8'h04, r); check(r == DESC_A, "R2 desc ptr readback", r, DESC_A);
            wr0 = n_wr; rd0 = n_rd;
            reg_wr(8'h00, 32'h1);
            wait_idle(idle);
            @(negedge clk);
            mem_compare("R3 R4 copy result");
            check(n_wr - wr0 == int'(VECS[v].len >> 2), "R3 write beats",
                  n_wr - wr0, VECS[v].len >> 2);
            check(n_rd - rd0 == 4 + int'(VECS[v].len >> 2), "R2 R10 read count",
                  n_rd - rd0, 4 + (VECS[v].len >> 2));
            if (VECS[v].len != 0)
                check(idle == last_wr_cyc + 1, "R5 run bit drop cycle", idle, last_wr_cyc + 1);
            reg_rd(8'h00, r);
            check(r == {29'b0, VECS[v].flags[0], 2'b0}, "R6 ctrl after completion",
                  r, {29'b0, VECS[v].flags[0], 2'b0});
            check(irq == VECS[v].flags[0], "R6 irq level", irq, VECS[v].flags[0]);
            if (v == 0) begin
                reg_wr(8'h00, 32'h0);
                check(irq == 1, "R7 write without bit2 keeps flag", irq, 1);
            end
            reg_wr(8'h00, 32'h4);
            check(irq == 0, "R7 write-one clears flag", irq, 0);
        end

        // R8: restart attempt while running
        fill(9);
        set_desc(DESC_A, '{32'h111, 32'h000, 32'h080, 32'd64, 1'b1});
        set_desc(DESC_B, '{32'h111, 32'h000, 32'h2C0, 32'd4, 1'b0});
        model('{32'h111, 32'h000, 32'h080, 32'd64, 1'b1});
        stall_mode = 1'b1;
        reg_wr(8'h04, DESC_A);
        wr0 = n_wr; rd0 = n_rd;
        reg_wr(8'h00, 32'h1);
        repeat (6) @(negedge clk);
        reg_wr(8'h04, DESC_B);
        reg_wr(8'h00, 32'h1);
        wait_idle(idle);
        repeat (20) @(negedge clk);
        reg_rd(8'h00, r);
        check(r[0] == 0, "R8 no restart after busy write", r, 32'h4);
        check(n_wr - wr0 == 16, "R8 no extra writes", n_wr - wr0, 16);
        check(n_rd - rd0 == 20, "R8 no extra reads", n_rd - rd0, 20);
        mem_compare("R8 memory untouched by ignored start");
        reg_rd(8'h04, r); check(r == DESC_B, "R2 ptr written while busy", r, DESC_B);
        reg_wr(8'h00, 32'h4);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule